// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a small 32-bit processor core that completes each instruction in a single clock cycle. It fetches the word addressed by the program counter from an internal instruction store and decodes the main control signals from the 6-bit opcode alone. It reads two registers, runs the ALU, optionally touches an internal data store, writes the register file, and picks the next program counter, all within that cycle. The core executes register-register add, subtract, and, or and set-less-than, plus load word, store word, branch-if-equal and jump. Every other opcode retires as a no-op.

Both stores are word-addressed arrays that are filled through a simple load port while the core is held in reset. Each cycle the core presents on its outputs the fetch address, the register write it is about to commit and the memory write it is about to commit. An observer can therefore follow execution instruction by instruction.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low the program counter reads 0 and neither `rf_we` nor `dm_we` is asserted.
- R2: An instruction with opcode bits [31:26] = 000000 writes register bits [15:11] with f(reg[25:21], reg[20:16]). The function is selected by bits [5:0]: 100000 add, 100010 subtract, 100100 and, 100101 or, 101010 signed set-less-than (result 1 or 0).
- R3: Opcode 100011 writes register bits [20:16] with the data word at byte address reg[25:21] + sign-extended bits [15:0].
- R4: Opcode 101011 stores reg[20:16] at byte address reg[25:21] + sign-extended bits [15:0] (`dm_we` high, `dm_addr`, `dm_wdata`). It writes no register.
- R5: Opcode 000100 branches to PC+4 + (sign-extended bits [15:0] << 2) when reg[25:21] equals reg[20:16], and goes to PC+4 otherwise. It writes no register or memory.
- R6: Opcode 000010 sets the next PC to {(PC+4)[31:28], bits [25:0], 00}. It writes no register or memory.
- R7: All instructions other than a taken branch or a jump advance the PC by 4.
- R8: Register 0 reads as zero even after an instruction has targeted it for writing.
- R9: Any opcode not listed in R2 to R6 writes no register and no memory and advances the PC by 4.
- R10: For register-register instructions, `alu_ovf` is high exactly when a signed add or subtract overflows 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; holds the core idle |
| ld_we | input | 1 | Load port write strobe |
| ld_to_dmem | input | 1 | Load target: 1 data store, 0 instruction store |
| ld_addr | input | MEM_AW | Word index for the load port |
| ld_data | input | 32 | Word written by the load port |
| pc_out | output | 32 | Address of the instruction executing this cycle |
| rf_we | output | 1 | Register write committed at the next edge |
| rf_waddr | output | 5 | Destination register |
| rf_wdata | output | 32 | Value written to the destination |
| dm_we | output | 1 | Data store write committed at the next edge |
| dm_addr | output | 32 | Byte address computed by the ALU |
| dm_wdata | output | 32 | Store data |
| alu_ovf | output | 1 | Signed overflow of the current ALU operation |

## Verification
All write and overflow outputs are combinational from the current PC, so they describe the instruction being executed in that same cycle. The register, memory and PC updates land at the next rising edge and only show up when a later instruction uses them. The bench releases reset on a falling edge and samples 1 ns after each falling edge. At each sample it pops one expected entry, which was produced by an instruction-level model of the requirements. Each entry therefore lines up with exactly one executed instruction, with no offset for the single-cycle path.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam logic [5:0] OP_REG  = 6'b000000;
  localparam logic [5:0] OP_LOAD = 6'b100011;
  localparam logic [5:0] OP_STOR = 6'b101011;
  localparam logic [5:0] OP_BEQ  = 6'b000100;
  localparam logic [5:0] OP_JMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_fn_e;

  typedef struct packed {
    logic       dst_rd;
    logic       src_imm;
    logic       wb_mem;
    logic       reg_we;
    logic       mem_rd;
    logic       mem_we;
    logic       br_eq;
    logic       jmp;
    logic [1:0] alu_mode;
  } ctrl_t;

  function automatic logic [31:0] sext16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic alu_fn_e alu_select(input logic [1:0] mode, input logic [5:0] fn);
    alu_fn_e sel;
    sel = ALU_ADD;
    if (mode == 2'b01) sel = ALU_SUB;
    else if (mode == 2'b10) begin
      case (fn)
        FN_SUB:  sel = ALU_SUB;
        FN_AND:  sel = ALU_AND;
        FN_OR:   sel = ALU_OR;
        FN_SLT:  sel = ALU_SLT;
        default: sel = ALU_ADD;
      endcase
    end
    return sel;
  endfunction

  function automatic logic [31:0] alu_result(input alu_fn_e f, input logic [31:0] a,
                                             input logic [31:0] b);
    case (f)
      ALU_SUB: return a - b;
      ALU_AND: return a & b;
      ALU_OR:  return a | b;
      ALU_SLT: return {31'd0, ($signed(a) < $signed(b))};
      default: return a + b;
    endcase
  endfunction

  function automatic logic alu_overflow(input alu_fn_e f, input logic [31:0] a,
                                        input logic [31:0] b, input logic [31:0] y);
    if (f == ALU_ADD) return (a[31] == b[31]) && (y[31] != a[31]);
    if (f == ALU_SUB) return (a[31] != b[31]) && (y[31] != a[31]);
    return 1'b0;
  endfunction

  function automatic logic [31:0] branch_target(input logic [31:0] pc4, input logic [15:0] off);
    return pc4 + {sext16(off)[29:0], 2'b00};
  endfunction

  function automatic logic [31:0] jump_target(input logic [31:0] pc4, input logic [25:0] idx);
    return {pc4[31:28], idx, 2'b00};
  endfunction

endpackage

// File: rtl/sc_main_decode.sv
module sc_main_decode
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl,
  output logic       known
);

  always_comb begin
    ctrl  = '0;
    known = 1'b1;
    case (opcode)
      OP_REG: begin
        ctrl.dst_rd = 1'b1; ctrl.reg_we = 1'b1; ctrl.alu_mode = 2'b10;
      end
      OP_LOAD: begin
        ctrl.src_imm = 1'b1; ctrl.wb_mem = 1'b1; ctrl.reg_we = 1'b1; ctrl.mem_rd = 1'b1;
      end
      OP_STOR: begin
        ctrl.src_imm = 1'b1; ctrl.mem_we = 1'b1;
      end
      OP_BEQ: begin
        ctrl.br_eq = 1'b1; ctrl.alu_mode = 2'b01;
      end
      OP_JMP: ctrl.jmp = 1'b1;
      default: known = 1'b0;
    endcase
  end

  // A decoded instruction does at most one kind of state change (R9 guards the rest)
  always_comb begin
    assert_ctrl_exclusive_R9: assert ($onehot0({ctrl.reg_we, ctrl.mem_we, ctrl.br_eq, ctrl.jmp}));
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_fn_e      fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero,
  output logic         ovf
);

  always_comb begin
    y    = alu_result(fn, a, b);
    ovf  = alu_overflow(fn, a, b, y);
    zero = (y == '0);
  end

  always_comb begin
    if (fn == ALU_SUB && zero) assert_eq_on_zero_R5: assert (a == b);
    if (ovf) assert_ovf_arith_only_R10: assert (fn == ALU_ADD || fn == ALU_SUB);
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  rda,
  output logic [W-1:0]  rdb
);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  assign rda = (ra == '0) ? '0 : regs[ra];
  assign rdb = (rb == '0) ? '0 : regs[rb];

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_we,
  input  logic              ld_to_dmem,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [31:0]       ld_data,
  output logic [31:0]       pc_out,
  output logic              rf_we,
  output logic [4:0]        rf_waddr,
  output logic [31:0]       rf_wdata,
  output logic              dm_we,
  output logic [31:0]       dm_addr,
  output logic [31:0]       dm_wdata,
  output logic              alu_ovf
);

  localparam int WORDS = 1 << MEM_AW;

  logic [31:0] imem [WORDS];
  logic [31:0] dmem [WORDS];
  logic [31:0] pc_q, pc_next, pc_plus4, instr;
  logic [31:0] rda, rdb, alu_b, alu_y, dm_rdata;
  logic        alu_zero, dec_known, br_taken;
  ctrl_t       ctrl;
  alu_fn_e     alu_fn;

  logic [5:0]  f_op, f_fn;
  logic [4:0]  f_rs, f_rt, f_rd;
  logic [15:0] f_imm;

  assign instr = imem[pc_q[MEM_AW+1:2]];
  assign f_op  = instr[31:26];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_imm = instr[15:0];
  assign f_fn  = instr[5:0];

  sc_main_decode u_dec (.opcode(f_op), .ctrl(ctrl), .known(dec_known));

  sc_regfile #(.NREG(32), .W(32)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra(f_rs), .rb(f_rt), .rda(rda), .rdb(rdb)
  );

  assign alu_fn = alu_select(ctrl.alu_mode, f_fn);
  assign alu_b  = ctrl.src_imm ? sext16(f_imm) : rdb;

  sc_alu #(.W(32)) u_alu (
    .fn(alu_fn), .a(rda), .b(alu_b), .y(alu_y), .zero(alu_zero), .ovf(alu_ovf)
  );

  assign dm_rdata = ctrl.mem_rd ? dmem[alu_y[MEM_AW+1:2]] : '0;
  assign rf_we    = ctrl.reg_we & rst_n;
  assign rf_waddr = ctrl.dst_rd ? f_rd : f_rt;
  assign rf_wdata = ctrl.wb_mem ? dm_rdata : alu_y;
  assign dm_we    = ctrl.mem_we & rst_n;
  assign dm_addr  = alu_y;
  assign dm_wdata = rdb;

  // Next PC selection: jump overrides branch, branch overrides sequential
  assign pc_plus4 = pc_q + 32'd4;
  assign br_taken = ctrl.br_eq & alu_zero;
  always_comb begin
    pc_next = pc_plus4;
    if (br_taken) pc_next = branch_target(pc_plus4, f_imm);
    if (ctrl.jmp) pc_next = jump_target(pc_plus4, instr[25:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (dm_we) dmem[alu_y[MEM_AW+1:2]] <= dm_wdata;
    else if (ld_we && ld_to_dmem) dmem[ld_addr] <= ld_data;
    if (ld_we && !ld_to_dmem) imem[ld_addr] <= ld_data;
  end

  assign pc_out = pc_q;

  // ---------------- assertions ----------------
  always_comb begin
    if (!rst_n) assert_idle_in_reset_R1: assert (!rf_we && !dm_we);
  end

  assert_pc_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_taken && !ctrl.jmp) |=> (pc_q == $past(pc_plus4)));

  assert_branch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> (pc_q == $past(pc_plus4) + {$past(sext16(f_imm)) , 2'b00}));

  assert_jump_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.jmp |=> (pc_q[27:0] == {$past(instr[25:0]), 2'b00}));

  assert_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (f_op == OP_STOR) |-> (dm_we && !rf_we));

  assert_unknown_nop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_known |-> (!rf_we && !dm_we));

  assert_r0_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_we && f_rt == 5'd0) |-> (dm_wdata == 32'd0));

endmodule

// File: tb/sc_core_bench.sv
module sc_core_bench;

  localparam int AW = 6;
  localparam int NW = 1 << AW;
  localparam int STEPS = 26;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, ld_we, ld_to_dmem;
  logic [AW-1:0] ld_addr;
  logic [31:0]   ld_data;
  logic [31:0]   pc_out, rf_wdata, dm_addr, dm_wdata;
  logic [4:0]    rf_waddr;
  logic          rf_we, dm_we, alu_ovf;

  sc_core #(.MEM_AW(AW)) u_sc_core (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_to_dmem(ld_to_dmem), .ld_addr(ld_addr),
    .ld_data(ld_data), .pc_out(pc_out), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
    .alu_ovf(alu_ovf)
  );

  typedef struct {
    logic [31:0] pc;
    logic        rwe;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic        mwe;
    logic [31:0] ma;
    logic [31:0] md;
    logic        chk_ovf;
    logic        ovf;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0, n_fail = 0;
  bit          mon_done = 0;
  logic [31:0] prog [NW];
  logic [31:0] dinit [NW];
  logic [31:0] m [NW];
  logic [31:0] r [32];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int word);
    return {6'b000010, 26'(word)};
  endfunction

  // Instruction-level model: pushes one expected item per executed instruction
  task automatic drive_expect();
    logic [31:0] pc = 0;
    for (int s = 0; s < STEPS; s++) begin
      exp_t        e;
      logic [31:0] ins = prog[pc[AW+1:2]];
      logic [31:0] a = r[ins[25:21]], b = r[ins[20:16]];
      logic [31:0] imm = {{16{ins[15]}}, ins[15:0]};
      logic [31:0] npc = pc + 4, res, ea;
      longint      wide;
      e = '{pc: pc, rwe: 0, wa: 0, wd: 0, mwe: 0, ma: 0, md: 0, chk_ovf: 0, ovf: 0, tag: "R9"};
      case (ins[31:26])
        6'b000000: begin
          wide = 0;
          case (ins[5:0])
            6'h22: begin res = a - b; wide = longint'($signed(a)) - longint'($signed(b)); end
            6'h24: res = a & b;
            6'h25: res = a | b;
            6'h2a: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: begin res = a + b; wide = longint'($signed(a)) + longint'($signed(b)); end
          endcase
          e.rwe = 1; e.wa = ins[15:11]; e.wd = res; e.chk_ovf = 1;
          e.ovf = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
          e.tag = (ins[15:11] == 0) ? "R8" : (e.ovf ? "R10" : "R2");
          if (ins[15:11] != 0) r[ins[15:11]] = res;
        end
        6'b100011: begin
          ea = a + imm;
          e.rwe = 1; e.wa = ins[20:16]; e.wd = m[ea[AW+1:2]]; e.tag = "R3";
          if (ins[20:16] != 0) r[ins[20:16]] = m[ea[AW+1:2]];
        end
        6'b101011: begin
          ea = a + imm;
          e.mwe = 1; e.ma = ea; e.md = b; e.tag = (ins[20:16] == 0) ? "R8" : "R4";
          m[ea[AW+1:2]] = b;
        end
        6'b000100: begin
          e.tag = "R5";
          if (a == b) npc = npc + (imm << 2);
        end
        6'b000010: begin
          e.tag = "R6";
          npc = {npc[31:28], ins[25:0], 2'b00};
        end
        default: ;
      endcase
      sb.push_back(e);
      pc = npc;
    end
  endtask

  // Monitor: one item per instruction, sampled 1 ns after each falling edge
  initial begin
    @(posedge rst_n);
    while (sb.size() > 0) begin
      exp_t e;
      #1;
      e = sb.pop_front();
      check(pc_out == e.pc, "R7", {e.tag, " pc"}, pc_out, e.pc);
      check(rf_we == e.rwe, e.tag, "rf_we", 32'(rf_we), 32'(e.rwe));
      if (e.rwe) begin
        check(rf_waddr == e.wa, e.tag, "rf_waddr", 32'(rf_waddr), 32'(e.wa));
        check(rf_wdata == e.wd, e.tag, "rf_wdata", rf_wdata, e.wd);
      end
      check(dm_we == e.mwe, e.tag, "dm_we", 32'(dm_we), 32'(e.mwe));
      if (e.mwe) begin
        check(dm_addr == e.ma, e.tag, "dm_addr", dm_addr, e.ma);
        check(dm_wdata == e.md, e.tag, "dm_wdata", dm_wdata, e.md);
      end
      if (e.chk_ovf) check(alu_ovf == e.ovf, "R10", "alu_ovf", 32'(alu_ovf), 32'(e.ovf));
      @(negedge clk);
    end
    mon_done = 1;
  end

  initial begin
    #(200000 * 8);
    check(1'b0, "watchdog", "timeout", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; ld_we = 0; ld_to_dmem = 0; ld_addr = '0; ld_data = '0;
    for (int i = 0; i < NW; i++) begin prog[i] = 32'd0; dinit[i] = 32'd0; end
    for (int i = 0; i < 32; i++) r[i] = 32'd0;
    dinit[0] = 32'h7FFF_FFFF; dinit[1] = 32'd1; dinit[2] = 32'hFFFF_FFF0; dinit[3] = 32'd5;
    prog[0]  = enc_i(6'b100011, 0, 1, 0);
    prog[1]  = enc_i(6'b100011, 0, 2, 4);
    prog[2]  = enc_r(1, 2, 3, 6'h20);
    prog[3]  = enc_r(2, 1, 4, 6'h22);
    prog[4]  = enc_r(1, 2, 5, 6'h24);
    prog[5]  = enc_r(3, 2, 6, 6'h25);
    prog[6]  = enc_r(3, 2, 7, 6'h2a);
    prog[7]  = enc_r(2, 3, 8, 6'h2a);
    prog[8]  = enc_r(1, 2, 0, 6'h20);
    prog[9]  = enc_i(6'b101011, 0, 0, 16);
    prog[10] = enc_i(6'b100011, 0, 9, 8);
    prog[11] = enc_i(6'b101011, 0, 9, 20);
    prog[12] = 32'hFC22_1800;
    prog[13] = enc_i(6'b000100, 2, 5, 2);
    prog[14] = enc_r(1, 1, 10, 6'h20);
    prog[15] = enc_r(1, 1, 10, 6'h20);
    prog[16] = enc_i(6'b000100, 2, 3, 5);
    prog[17] = enc_j(20);
    prog[18] = enc_r(1, 1, 11, 6'h20);
    prog[19] = enc_r(1, 1, 11, 6'h20);
    prog[20] = enc_r(3, 2, 12, 6'h22);
    prog[21] = enc_i(6'b000100, 0, 0, -1);
    for (int i = 0; i < NW; i++) m[i] = dinit[i];

    for (int i = 0; i < 2 * NW; i++) begin
      @(negedge clk);
      ld_we = 1; ld_to_dmem = (i >= NW); ld_addr = AW'(i % NW);
      ld_data = (i >= NW) ? dinit[i % NW] : prog[i % NW];
    end
    @(negedge clk);
    ld_we = 0;
    #1;
    check(pc_out == 32'd0, "R1", "pc in reset", pc_out, 0);
    check(!rf_we, "R1", "rf_we in reset", 32'(rf_we), 0);
    check(!dm_we, "R1", "dm_we in reset", 32'(dm_we), 0);

    drive_expect();
    @(negedge clk);
    rst_n = 1;
    wait (mon_done);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule